// File: doc/BRIEF.md
# Half-Pumped Warp Register File

This block stores the per-thread architectural registers of every warp resident in one SIMD core. A warp is a group of lanes that execute together, each lane holding its own copy of every register. The storage port is half as wide as a warp. A single request names a warp and a register. The block moves that warp-wide operand in two beats on consecutive cycles: the lower half of the lanes first, then the upper half. To the requester, one warp access looks like a single wide access that takes one extra cycle.

A small two-state controller sequences each access. In state `HP_IDLE` the block raises `req_ready`. An accepted request performs its lower-half beat on the accepting clock edge, and the controller then moves to `HP_UPPER` (transition "accept"). In `HP_UPPER` the block lowers `req_ready`, performs the upper-half beat, and returns to `HP_IDLE` (transition "finish"). With no request pending, `HP_IDLE` holds (transition "wait"). Writes carry a full warp of data and a per-lane mask, so lanes of inactive threads keep their old contents. Storage is split into one bank per physical lane. Each bank row is addressed by warp, register and half.

Top module: `half_pumped_regfile`

## Requirements
- R1: After reset, `req_ready` is 1 and `rd_valid` is 0.
- R2: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both 1. In the cycle after any accept, `req_ready` is 0 for exactly one cycle and then returns to 1.
- R3: In the cycle after a read is accepted, `rd_valid` is 1, `rd_beat` is 0, and `rd_data` lane k carries warp lane k, for k from 0 to PORT_LANES-1. Lane k sits at bits k*DATA_W and up.
- R4: In the cycle after the first beat, `rd_valid` is 1, `rd_beat` is 1, and `rd_data` lane k carries warp lane PORT_LANES+k.
- R5: A write stores `req_wdata` lane j (bits j*DATA_W and up) into warp lane j only when `req_mask` bit j is 1. Lanes whose mask bit is 0 keep their previous value.
- R6: Write data and mask are sampled only on the accepting edge. Any change to them during the busy cycle has no effect on what is stored.
- R7: A request held on the inputs while `req_ready` is 0 is not taken. It is accepted on the next edge, after `req_ready` returns to 1.
- R8: A read accepted immediately after a write completes, to the same warp and register, returns the newly written values in both beats.
- R9: Each pair of warp index (below NUM_WARPS) and register index (below NUM_REGS) addresses storage that is separate from every other pair.
- R10: `rd_valid` is 0 in any cycle that does not follow a read beat, including the cycle after a write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_warp | input | WARP_W | Warp index |
| req_reg | input | REG_W | Register index within each thread |
| req_mask | input | 2*PORT_LANES | Per-lane write enable |
| req_wdata | input | 2*PORT_LANES*DATA_W | Full-warp write data |
| rd_valid | output | 1 | A read beat is on `rd_data` |
| rd_beat | output | 1 | 0 = lower lanes, 1 = upper lanes |
| rd_data | output | PORT_LANES*DATA_W | Half-warp read data |

## Verification
The bound checker checks the handshake timing on every cycle: the single-cycle drop of `req_ready` after each accept, the beat order of a read, the absence of `rd_valid` after a write, and the range of accepted warp indices. Only the bench's scenarios can show that the stored data is right. The bench uses a small configuration. It fills every warp and register, applies a masked write to each, and reads all of them back against a model computed from the patterns. It also covers corruption of write inputs during the busy cycle, a request held through the stall, and a read that follows a write back to back.

// File: rtl/hprf_pkg.sv
package hprf_pkg;
    typedef enum logic {
        HP_IDLE  = 1'b0,
        HP_UPPER = 1'b1
    } hp_state_e;
endpackage

// File: rtl/hprf_ctrl.sv
module hprf_ctrl
    import hprf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic low_go,
    output logic high_go,
    output logic high_write
);
    hp_state_e state_q;
    hp_state_e state_d;
    logic      write_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HP_IDLE;
        else        state_q <= state_d;
    end

    // Operation kind is carried into the upper beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      write_q <= 1'b0;
        else if (low_go) write_q <= req_write;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HP_IDLE:  if (req_valid) state_d = HP_UPPER;
            HP_UPPER: state_d = HP_IDLE;
            default:  state_d = HP_IDLE;
        endcase
    end

    always_comb begin
        req_ready  = 1'b0;
        low_go     = 1'b0;
        high_go    = 1'b0;
        high_write = 1'b0;
        unique case (state_q)
            HP_IDLE: begin
                req_ready = 1'b1;
                low_go    = req_valid;
            end
            HP_UPPER: begin
                high_go    = 1'b1;
                high_write = write_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hprf_row_map.sv
module hprf_row_map #(
    parameter int NUM_REGS = 4,
    parameter int WARP_W   = 3,
    parameter int REG_W    = 2,
    parameter int BASE_W   = 5
) (
    input  logic [WARP_W-1:0] warp,
    input  logic [REG_W-1:0]  reg_idx,
    output logic [BASE_W-1:0] base
);
    // Row group for a (warp, register) pair; each group holds two half rows
    assign base = BASE_W'(warp) * BASE_W'(NUM_REGS) + BASE_W'(reg_idx);
endmodule

// File: rtl/hprf_lane_bank.sv
module hprf_lane_bank #(
    parameter int ROWS   = 64,
    parameter int ROW_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (we) cells[row] <= wdata;
    end

    assign rdata = cells[row];
endmodule

// File: rtl/half_pumped_regfile.sv
module half_pumped_regfile #(
    parameter int NUM_WARPS  = 8,
    parameter int NUM_REGS   = 4,
    parameter int PORT_LANES = 16,
    parameter int DATA_W     = 32,
    localparam int WARP_LANES = 2 * PORT_LANES,
    localparam int WARP_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int REG_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [WARP_W-1:0]            req_warp,
    input  logic [REG_W-1:0]             req_reg,
    input  logic [WARP_LANES-1:0]        req_mask,
    input  logic [WARP_LANES*DATA_W-1:0] req_wdata,
    output logic                         rd_valid,
    output logic                         rd_beat,
    output logic [PORT_LANES*DATA_W-1:0] rd_data
);
    localparam int SLOTS  = NUM_WARPS * NUM_REGS;
    localparam int BASE_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int ROW_W  = BASE_W + 1;
    localparam int ROWS   = 2 * SLOTS;
    localparam int HALF_W = PORT_LANES * DATA_W;

    logic                  low_go, high_go, high_write;
    logic [BASE_W-1:0]     base_now, base_q;
    logic [PORT_LANES-1:0] mask_hi_q;
    logic [HALF_W-1:0]     data_hi_q;
    logic [ROW_W-1:0]      row_sel;
    logic [HALF_W-1:0]     half_rd;

    hprf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_ready  (req_ready),
        .low_go     (low_go),
        .high_go    (high_go),
        .high_write (high_write)
    );

    hprf_row_map #(
        .NUM_REGS (NUM_REGS),
        .WARP_W   (WARP_W),
        .REG_W    (REG_W),
        .BASE_W   (BASE_W)
    ) u_map (
        .warp    (req_warp),
        .reg_idx (req_reg),
        .base    (base_now)
    );

    // Upper-half context captured on the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            mask_hi_q <= '0;
            data_hi_q <= '0;
        end else if (low_go) begin
            base_q    <= base_now;
            mask_hi_q <= req_mask[WARP_LANES-1:PORT_LANES];
            data_hi_q <= req_wdata[WARP_LANES*DATA_W-1:HALF_W];
        end
    end

    assign row_sel = high_go ? {base_q, 1'b1} : {base_now, 1'b0};

    for (genvar l = 0; l < PORT_LANES; l++) begin : g_lane
        logic              lane_we;
        logic [DATA_W-1:0] lane_wd;

        assign lane_we = (low_go & req_write & req_mask[l]) |
                         (high_go & high_write & mask_hi_q[l]);
        assign lane_wd = high_go ? data_hi_q[l*DATA_W +: DATA_W]
                                 : req_wdata[l*DATA_W +: DATA_W];

        hprf_lane_bank #(
            .ROWS   (ROWS),
            .ROW_W  (ROW_W),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk   (clk),
            .we    (lane_we),
            .row   (row_sel),
            .wdata (lane_wd),
            .rdata (half_rd[l*DATA_W +: DATA_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_beat  <= 1'b0;
            rd_data  <= '0;
        end else if (low_go && !req_write) begin
            rd_valid <= 1'b1;
            rd_beat  <= 1'b0;
            rd_data  <= half_rd;
        end else if (high_go && !high_write) begin
            rd_valid <= 1'b1;
            rd_beat  <= 1'b1;
            rd_data  <= half_rd;
        end else begin
            rd_valid <= 1'b0;
            rd_beat  <= 1'b0;
        end
    end
endmodule

// File: rtl/hprf_chk.sv
module hprf_chk #(
    parameter int NUM_WARPS = 8,
    parameter int WARP_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [WARP_W-1:0] req_warp,
    input logic              rd_valid,
    input logic              rd_beat
);
    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    // R3
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> (rd_valid && !rd_beat));

    // R4
    second_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_beat) |=> (rd_valid && rd_beat));

    // R10
    no_data_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> !rd_valid);

    // R10
    beat_pair_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_beat && !(req_valid && req_ready && !req_write)) |=> !rd_valid);

    // R9
    warp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (int'(req_warp) < NUM_WARPS));
endmodule

bind half_pumped_regfile hprf_chk #(
    .NUM_WARPS (NUM_WARPS),
    .WARP_W    (WARP_W)
) u_hprf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_warp  (req_warp),
    .rd_valid  (rd_valid),
    .rd_beat   (rd_beat)
);

// File: tb/test_half_pumped_regfile.sv
`timescale 1ns/1ps
module test_half_pumped_regfile;
    localparam int NW = 6;
    localparam int NR = 3;
    localparam int PL = 4;
    localparam int DW = 8;
    localparam int WL = 2 * PL;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [2:0]        req_warp = '0;
    logic [1:0]        req_reg = '0;
    logic [WL-1:0]     req_mask = '0;
    logic [WL*DW-1:0]  req_wdata = '0;
    logic              rd_valid;
    logic              rd_beat;
    logic [PL*DW-1:0]  rd_data;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [NW][NR][WL];

    always #10 clk = ~clk;

    half_pumped_regfile #(
        .NUM_WARPS (NW), .NUM_REGS (NR), .PORT_LANES (PL), .DATA_W (DW)
    ) i_half_pumped_regfile (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_write (req_write), .req_warp (req_warp), .req_reg (req_reg),
        .req_mask (req_mask), .req_wdata (req_wdata), .rd_valid (rd_valid),
        .rd_beat (rd_beat), .rd_data (rd_data)
    );

    function automatic logic [DW-1:0] pat(int w, int r, int l, int s);
        return DW'(w * 40 + r * 13 + l * 7 + s * 29 + 3);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_write(int w, int r, logic [WL-1:0] m, int s);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_warp  = 3'(w);
        req_reg   = 2'(r);
        req_mask  = m;
        for (int l = 0; l < WL; l++) begin
            req_wdata[l*DW +: DW] = pat(w, r, l, s);
            if (m[l]) model[w][r][l] = pat(w, r, l, s);
        end
    endtask

    task automatic check_half(int w, int r, int hb, string req);
        for (int k = 0; k < PL; k++)
            check(req, 64'(rd_data[k*DW +: DW]), 64'(model[w][r][hb*PL + k]));
    endtask

    // Entered and left just after a falling edge with the block idle
    task automatic do_write(int w, int r, logic [WL-1:0] m, int s);
        drive_write(w, r, m, s);
        @(negedge clk);
        req_valid = 1'b0;
        req_mask  = ~req_mask;   // R6: corrupted during the busy cycle
        req_wdata = ~req_wdata;
        check("R2 busy", 64'(req_ready), 64'd0);
        check("R10 write", 64'(rd_valid), 64'd0);
        @(negedge clk);
        check("R2 ready", 64'(req_ready), 64'd1);
    endtask

    task automatic do_read(int w, int r);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_warp  = 3'(w);
        req_reg   = 2'(r);
        @(negedge clk);
        req_valid = 1'b0;
        check("R3 valid", 64'({rd_valid, rd_beat}), 64'b10);
        check_half(w, r, 0, "R3 R9 lower");
        @(negedge clk);
        check("R4 valid", 64'({rd_valid, rd_beat}), 64'b11);
        check_half(w, r, 1, "R4 R9 upper");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ready", 64'(req_ready), 64'd1);
        check("R1 valid", 64'(rd_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", 64'(rd_valid), 64'd0);

        for (int w = 0; w < NW; w++)
            for (int r = 0; r < NR; r++)
                do_write(w, r, '1, 0);
        // R5 R6: masked overwrite of every slot
        for (int w = 0; w < NW; w++)
            for (int r = 0; r < NR; r++)
                do_write(w, r, WL'(w * 37 + r * 11 + 5), 1);
        for (int w = 0; w < NW; w++)
            for (int r = 0; r < NR; r++) begin
                do_read(w, r);
                @(negedge clk);
                check("R10 idle", 64'(rd_valid), 64'd0);
            end

        // R7 R8: write, then a read held on the inputs through the stall
        drive_write(4, 2, 8'b1010_0110, 2);
        @(negedge clk);
        req_write = 1'b0;
        check("R7 stall", 64'(req_ready), 64'd0);
        @(negedge clk);
        check("R7 taken", 64'(req_ready), 64'd1);
        check("R7 no read yet", 64'(rd_valid), 64'd0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 valid", 64'({rd_valid, rd_beat}), 64'b10);
        check_half(4, 2, 0, "R8 lower");
        @(negedge clk);
        check("R8 valid", 64'({rd_valid, rd_beat}), 64'b11);
        check_half(4, 2, 1, "R8 upper");
        @(negedge clk);
        check("R5 zero mask", 64'(rd_valid), 64'd0);
        do_write(0, 1, '0, 3);   // R5: nothing stored
        do_read(0, 1);
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule